// File: doc/BRIEF.md
# Two-Way Write-Through Data Cache

This block is a private data cache for a single execution thread. It sits between a load-store unit and a memory controller. Words are addressed with 8 bits, and each cache line holds exactly one word. The word width is a parameter, normally 32 bits or 128 bits. The store has 16 sets of two ways each. Every set has one replacement bit, which names the way to evict next.

A request is accepted when the valid and ready signals are both high on a clock edge. The tag compare runs on the cycle after acceptance, from registered copies of the request. A read hit therefore answers one cycle after the accepting edge.

A read miss sends a single word read to memory. The returned word is written into the victim way on the next cycle, and it is returned to the requester in that same cycle. Every write is forwarded to memory. A write that hits also updates the cached copy, and a write that misses leaves the cache unchanged. Only one request is in progress at a time: ready stays low from acceptance until the response has been given.

Top module: `wt_dcache`

## Requirements
- R1: While reset is active, and directly after it, every line is invalid, `req_ready_o` is 1, and `rsp_valid_o` and `mem_req_valid_o` are 0. A read of any address after reset is a miss.
- R2: The set index is address bits [3:0] and the tag is address bits [7:4]. Addresses that share a set but differ in tag can be held in the two ways at the same time.
- R3: A read hit raises `rsp_valid_o` for one cycle, one cycle after the accepting edge, with the stored word. It makes no memory request.
- R4: A read miss issues exactly one memory read (`mem_req_write_o`=0) for the requested address. The response comes in the cycle after the one where `mem_rsp_valid_i` is sampled, and it carries the memory word.
- R5: A fill goes to an invalid way if one exists, with way 0 before way 1. Otherwise it goes to the way that the set's replacement bit names.
- R6: A read hit, a write hit and a fill each set the replacement bit of their set to the other way from the one just used.
- R7: Every write issues exactly one memory write with the request's address and data. `rsp_valid_o` is raised in the cycle after memory accepts the write. A write hit updates the cached word. A write miss allocates no line.
- R8: `req_ready_o` is low from the accepting edge until the response cycle has passed. A request offered while ready is low is ignored and causes no memory traffic.
- R9: A memory request stays valid, with the same address, write flag and data, until `mem_req_ready_i` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request from the load-store unit |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Cache is idle and takes a request |
| rsp_valid_o | output | 1 | Read data or write acknowledge |
| rsp_rdata_o | output | DATA_W | Read data |
| mem_req_valid_o | output | 1 | Memory request |
| mem_req_write_o | output | 1 | Memory request is a write |
| mem_req_addr_o | output | ADDR_W | Memory word address |
| mem_req_wdata_o | output | DATA_W | Memory write data |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_rsp_valid_i | input | 1 | Memory read data valid |
| mem_rsp_rdata_i | input | DATA_W | Memory read data |

## Verification
The properties assume the following about the memory side. `mem_rsp_valid_i` is pulsed once for each accepted read, only after that read was accepted, and memory never answers a write. The bench memory follows this: it drives ready and response on the falling edge, with a programmable number of ready-stall cycles and a programmable read latency. The requester side is also free to hold `req_valid_i` high, with changing contents, while the cache is busy. The bench does exactly that, to show such requests are ignored.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

  localparam int unsigned NUM_WAYS = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_MEM_REQ,
    ST_MEM_WAIT,
    ST_FILL,
    ST_WR_ACK
  } dc_state_e;

endpackage

// File: rtl/wt_dcache_way.sv
module wt_dcache_way #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned TAG_W    = 4,
  parameter int unsigned DATA_W   = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              vld_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);

  logic [NUM_SETS-1:0] vld_q;
  logic [TAG_W-1:0]    tag_q  [NUM_SETS];
  logic [DATA_W-1:0]   data_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= '0;
    else if (we_i) vld_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (we_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      data_q[idx_i] <= wr_data_i;
    end
  end

  assign vld_o  = vld_q[idx_i];
  assign tag_o  = tag_q[idx_i];
  assign data_o = data_q[idx_i];

endmodule

// File: rtl/wt_dcache_lru.sv
module wt_dcache_lru #(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned IDX_W    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             touch_i,
  input  logic             used_way_i,
  output logic             evict_way_o
);

  // one bit per set: the way to replace next
  logic [NUM_SETS-1:0] evict_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evict_q <= '0;
    else if (touch_i) evict_q[idx_i] <= ~used_way_i;
  end

  assign evict_way_o = evict_q[idx_i];

endmodule

// File: rtl/wt_dcache_ctrl.sv
module wt_dcache_ctrl
  import wt_dcache_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  logic      wr_i,
  input  logic      hit_i,
  input  logic      mem_ready_i,
  input  logic      mem_rsp_valid_i,
  output dc_state_e state_o,
  output logic      req_ready_o,
  output logic      accept_o,
  output logic      mem_req_valid_o,
  output logic      fill_cap_o
);

  dc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (req_valid_i) state_d = ST_LOOKUP;
      ST_LOOKUP:   state_d = (hit_i && !wr_i) ? ST_IDLE : ST_MEM_REQ;
      ST_MEM_REQ:  if (mem_ready_i) state_d = wr_i ? ST_WR_ACK : ST_MEM_WAIT;
      ST_MEM_WAIT: if (mem_rsp_valid_i) state_d = ST_FILL;
      ST_FILL:     state_d = ST_IDLE;
      ST_WR_ACK:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o         = state_q;
  assign req_ready_o     = (state_q == ST_IDLE);
  assign accept_o        = req_ready_o && req_valid_i;
  assign mem_req_valid_o = (state_q == ST_MEM_REQ);
  assign fill_cap_o      = (state_q == ST_MEM_WAIT) && mem_rsp_valid_i;

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wt_dcache_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_SETS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              mem_req_valid_o,
  output logic              mem_req_write_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  output logic [DATA_W-1:0] mem_req_wdata_o,
  input  logic              mem_req_ready_i,
  input  logic              mem_rsp_valid_i,
  input  logic [DATA_W-1:0] mem_rsp_rdata_i
);

  localparam int unsigned IDX_W = $clog2(NUM_SETS);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  dc_state_e         state;
  logic              accept, fill_cap;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, fill_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;

  logic [NUM_WAYS-1:0] way_vld, way_hit, way_we;
  logic [TAG_W-1:0]    way_tag  [NUM_WAYS];
  logic [DATA_W-1:0]   way_data [NUM_WAYS];
  logic [DATA_W-1:0]   way_wdata;
  logic                hit, hit_way, lru_way, victim, in_lookup, in_fill;

  // request capture: lookup runs on the registered copy
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr_i;
      wr_q    <= req_write_i;
      wdata_q <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       fill_q <= '0;
    else if (fill_cap) fill_q <= mem_rsp_rdata_i;
  end

  assign idx = addr_q[IDX_W-1:0];
  assign tag = addr_q[ADDR_W-1:IDX_W];

  wt_dcache_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .wr_i            (wr_q),
    .hit_i           (hit),
    .mem_ready_i     (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .state_o         (state),
    .req_ready_o     (req_ready_o),
    .accept_o        (accept),
    .mem_req_valid_o (mem_req_valid_o),
    .fill_cap_o      (fill_cap)
  );

  assign in_lookup = (state == ST_LOOKUP);
  assign in_fill   = (state == ST_FILL);

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign way_hit[w] = way_vld[w] && (way_tag[w] == tag);
    assign way_we[w]  = (in_lookup && wr_q && way_hit[w]) ||
                        (in_fill && (victim == w[0]));

    wt_dcache_way #(
      .NUM_SETS (NUM_SETS),
      .IDX_W    (IDX_W),
      .TAG_W    (TAG_W),
      .DATA_W   (DATA_W)
    ) u_way (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idx_i     (idx),
      .we_i      (way_we[w]),
      .wr_tag_i  (tag),
      .wr_data_i (way_wdata),
      .vld_o     (way_vld[w]),
      .tag_o     (way_tag[w]),
      .data_o    (way_data[w])
    );
  end

  assign hit       = |way_hit;
  assign hit_way   = way_hit[1];
  assign way_wdata = in_fill ? fill_q : wdata_q;

  // invalid way first, else the replacement bit
  assign victim = !way_vld[0] ? 1'b0 :
                  !way_vld[1] ? 1'b1 : lru_way;

  wt_dcache_lru #(
    .NUM_SETS (NUM_SETS),
    .IDX_W    (IDX_W)
  ) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .idx_i       (idx),
    .touch_i     ((in_lookup && hit) || in_fill),
    .used_way_i  (in_fill ? victim : hit_way),
    .evict_way_o (lru_way)
  );

  assign rsp_valid_o = (in_lookup && hit && !wr_q) || in_fill || (state == ST_WR_ACK);
  assign rsp_rdata_o = in_fill                      ? fill_q :
                       (in_lookup && hit && !wr_q) ? way_data[hit_way] : '0;

  assign mem_req_write_o = wr_q;
  assign mem_req_addr_o  = addr_q;
  assign mem_req_wdata_o = wdata_q;

endmodule

// File: rtl/wt_dcache_chk.sv
module wt_dcache_chk #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [DATA_W-1:0] rsp_rdata_o,
  input logic              mem_req_valid_o,
  input logic              mem_req_write_o,
  input logic [ADDR_W-1:0] mem_req_addr_o,
  input logic [DATA_W-1:0] mem_req_wdata_o,
  input logic              mem_req_ready_i,
  input logic              mem_rsp_valid_i,
  input logic [DATA_W-1:0] mem_rsp_rdata_i
);

  logic rd_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_pend_q <= 1'b0;
    else if (mem_req_valid_o && mem_req_ready_i && !mem_req_write_o) rd_pend_q <= 1'b1;
    else if (mem_rsp_valid_i) rd_pend_q <= 1'b0;
  end

  // R8
  busy_after_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  // R8
  rsp_while_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  // R9
  mem_req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o)
      && $stable(mem_req_write_o) && $stable(mem_req_wdata_o));

  // R4
  fill_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pend_q && mem_rsp_valid_i |=> rsp_valid_o && (rsp_rdata_o == $past(mem_rsp_rdata_i)));

  // R7
  write_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_ready_i && mem_req_write_o |=> rsp_valid_o);

  // R3
  no_rsp_in_mem_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !rsp_valid_o);

endmodule

bind wt_dcache wt_dcache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/wt_dcache_tb_top.sv
module wt_dcache_tb_top;

  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_wdata_i = '0;
  logic          req_ready_o, rsp_valid_o;
  logic [DW-1:0] rsp_rdata_o;
  logic          mem_req_valid_o, mem_req_write_o;
  logic [AW-1:0] mem_req_addr_o;
  logic [DW-1:0] mem_req_wdata_o;
  logic          mem_req_ready_i = 1'b0, mem_rsp_valid_i = 1'b0;
  logic [DW-1:0] mem_rsp_rdata_i = '0;

  always #10 clk = ~clk;

  wt_dcache dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
    .rsp_rdata_o(rsp_rdata_o), .mem_req_valid_o(mem_req_valid_o),
    .mem_req_write_o(mem_req_write_o), .mem_req_addr_o(mem_req_addr_o),
    .mem_req_wdata_o(mem_req_wdata_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_rsp_valid_i(mem_rsp_valid_i), .mem_rsp_rdata_i(mem_rsp_rdata_i)
  );

  int checks = 0, fails = 0;

  task automatic check(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem_arr [256];
  logic [DW-1:0] golden  [256];
  int stall_cfg = 0, lat_cfg = 1, wait_cnt = 0, timer = 0;
  int n_rd = 0, n_wr = 0;
  logic [AW-1:0] pend_addr = '0, last_rd_addr = '0, last_wr_addr = '0;
  logic [DW-1:0] last_wr_data = '0;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid_o && mem_req_ready_i) begin
      if (mem_req_write_o) begin
        mem_arr[mem_req_addr_o] = mem_req_wdata_o;
        last_wr_addr = mem_req_addr_o;
        last_wr_data = mem_req_wdata_o;
        n_wr++;
      end else begin
        pend_addr = mem_req_addr_o;
        last_rd_addr = mem_req_addr_o;
        timer = lat_cfg;
        n_rd++;
      end
    end
  end

  always @(negedge clk) begin
    if (mem_req_valid_o) begin
      mem_req_ready_i = (wait_cnt >= stall_cfg);
      wait_cnt++;
    end else begin
      mem_req_ready_i = 1'b0;
      wait_cnt = 0;
    end
    mem_rsp_valid_i = 1'b0;
    if (timer > 0) begin
      timer--;
      if (timer == 0) begin
        mem_rsp_valid_i = 1'b1;
        mem_rsp_rdata_i = mem_arr[pend_addr];
      end
    end
  end

  // ---------------- behavioural reference ----------------
  bit       m_vld [16][2];
  bit [3:0] m_tag [16][2];
  bit       m_evict [16];

  task automatic model_clear();
    for (int s = 0; s < 16; s++) begin
      m_vld[s][0] = 0; m_vld[s][1] = 0; m_evict[s] = 0;
    end
  endtask

  function automatic int model_find(logic [7:0] a);
    for (int w = 0; w < 2; w++)
      if (m_vld[a[3:0]][w] && m_tag[a[3:0]][w] == a[7:4]) return w;
    return -1;
  endfunction

  task automatic run_req(bit wr, logic [7:0] a, logic [DW-1:0] d, int stall, int lat,
                         bit junk, string rq);
    int way, exp_lat, cyc, rd0, wr0, ready_seen, vic;
    bit got;
    logic [DW-1:0] rdata;
    int s;
    s = int'(a[3:0]);
    stall_cfg = stall; lat_cfg = lat;
    way = model_find(a);
    if (wr) exp_lat = 3 + stall;
    else if (way >= 0) exp_lat = 1;
    else exp_lat = 3 + stall + lat;
    @(negedge clk);
    check(req_ready_o == 1'b1, "R8", "ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = a; req_wdata_i = d;
    rd0 = n_rd; wr0 = n_wr;
    cyc = 0; got = 0; ready_seen = 0; rdata = '0;
    while (!got && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (junk) begin
        req_write_i = 1'b1; req_addr_i = ~a; req_wdata_i = '1;
      end else req_valid_i = 1'b0;
      if (req_ready_o) ready_seen++;
      if (rsp_valid_o) begin got = 1; rdata = rsp_rdata_o; end
    end
    req_valid_i = 1'b0;
    check(got && cyc == exp_lat, rq, "response cycle", 64'(cyc), 64'(exp_lat));
    check(ready_seen == 0, "R8", "ready low while busy", 64'(ready_seen), 64'd0);
    if (!wr) begin
      check(rdata == golden[a], rq, "read data", 64'(rdata), 64'(golden[a]));
      check(n_rd - rd0 == ((way >= 0) ? 0 : 1), rq, "memory reads", 64'(n_rd - rd0),
            64'((way >= 0) ? 0 : 1));
      check(n_wr == wr0, "R8", "no memory write on read", 64'(n_wr - wr0), 64'd0);
      if (way < 0) check(last_rd_addr == a, "R4", "read address", 64'(last_rd_addr), 64'(a));
    end else begin
      check(n_wr - wr0 == 1 && n_rd == rd0, "R7", "one memory write", 64'(n_wr - wr0), 64'd1);
      check(last_wr_addr == a && last_wr_data == d, "R7", "write address/data",
            64'(last_wr_data), 64'(d));
    end
    @(negedge clk);
    check(!rsp_valid_o && !mem_req_valid_o && req_ready_o, "R8", "idle after response",
          64'({rsp_valid_o, mem_req_valid_o, req_ready_o}), 64'b001);
    // reference update
    if (wr) begin
      golden[a] = d;
      if (way >= 0) m_evict[s] = (way == 0);
    end else if (way >= 0) begin
      m_evict[s] = (way == 0);
    end else begin
      vic = !m_vld[s][0] ? 0 : !m_vld[s][1] ? 1 : int'(m_evict[s]);
      m_vld[s][vic] = 1; m_tag[s][vic] = a[7:4];
      m_evict[s] = (vic == 0);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    timer = 0;
    repeat (2) @(negedge clk);
    check(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R1", "outputs in reset",
          64'({req_ready_o, rsp_valid_o, mem_req_valid_o}), 64'b100);
    rst_n = 1'b1;
    model_clear();
    @(negedge clk);
    check(req_ready_o && !rsp_valid_o && !mem_req_valid_o, "R1", "outputs after reset",
          64'({req_ready_o, rsp_valid_o, mem_req_valid_o}), 64'b100);
  endtask

  initial begin
    #4000000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit [31:0] lcg;
    for (int i = 0; i < 256; i++) begin
      mem_arr[i] = 32'h5a00_0000 ^ (i * 32'h0001_0203);
      golden[i]  = mem_arr[i];
    end
    model_clear();
    do_reset();

    run_req(0, 8'h05, '0, 0, 1, 0, "R1");          // cold miss after reset
    run_req(0, 8'h05, '0, 0, 1, 0, "R3");          // hit
    run_req(0, 8'h15, '0, 0, 1, 0, "R2");          // same set, other tag: way 1
    run_req(0, 8'h05, '0, 0, 1, 0, "R2");          // both resident
    run_req(0, 8'h15, '0, 0, 1, 0, "R3");
    run_req(0, 8'h25, '0, 0, 1, 0, "R5");          // evicts 0x05
    run_req(0, 8'h15, '0, 0, 1, 0, "R6");          // still hits
    run_req(0, 8'h05, '0, 0, 1, 0, "R5");          // miss, evicts 0x25
    run_req(0, 8'h25, '0, 0, 1, 0, "R6");          // miss again
    run_req(1, 8'h25, 32'hdead_beef, 0, 1, 0, "R7"); // write hit
    run_req(0, 8'h25, '0, 0, 1, 0, "R7");          // hit returns new word
    run_req(1, 8'h77, 32'h1234_5678, 2, 1, 0, "R7"); // write miss, stalled memory
    run_req(0, 8'h77, '0, 0, 1, 0, "R7");          // no allocation: miss
    run_req(0, 8'h3c, '0, 3, 5, 0, "R4");          // slow memory
    run_req(0, 8'h4c, '0, 1, 2, 1, "R8");          // busy requests ignored
    run_req(1, 8'h4c, 32'h0bad_f00d, 2, 1, 1, "R9");
    run_req(0, 8'h4c, '0, 0, 1, 0, "R3");

    do_reset();
    run_req(0, 8'h25, '0, 0, 1, 0, "R1");          // was cached, now a miss

    lcg = 32'h1f2e_3d4c;
    for (int n = 0; n < 200; n++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      run_req(lcg[25:24] == 2'd0, {1'b0, lcg[18:16], 2'b00, lcg[13:12]}, lcg, int'(lcg[21:20]),
              1 + int'(lcg[23:22]), lcg[27], "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule